// File: doc/BRIEF.md
# Dual-Bank Reloadable FIR Filter

This block is a direct-form FIR filter with a fixed number of signed taps. Its coefficients are held in two register banks. Either bank can be rewritten at run time while the filter keeps producing results. Input samples arrive on a valid-qualified stream. Each accepted sample produces one full-precision result on an output stream, a fixed number of cycles later.

To reload a bank, assert a load request for one cycle with the target bank on the bank-select input. The block takes one coefficient word per cycle, starting in the cycle after the request, until every tap is written. Words are stored in arrival order. The caller must already have arranged them in the filter's tap order. The new words collect in a staging area. The target bank takes the whole new set in a single cycle, at the end of the cycle that carries the last word, so no sample ever sees a half-written bank. A separate input picks which bank the filter computes with, once per sample. Reset discards every reloaded value and restores the built-in defaults.

Top module: `fir_reload_top`

## Requirements
- R1: After reset, `out_valid` and `load_done` are low. Bank 0 holds c[i] = i+1 and bank 1 holds c[i] = 16-4*i, for tap index i = 0..NTAPS-1.
- R2: For a sample accepted with bank b, the result is y = sum over i of c_b[i]*x[n-i]. Here x[n] is the newest sample, and samples before reset count as zero. The result is a signed, full-precision value of DW+CW+clog2(NTAPS) bits, so 8 taps of -128*-128 give 131072.
- R3: A sample accepted on `in_valid` in cycle k gives exactly one result, with `out_valid` high in cycle k+2. `out_valid` is never high otherwise.
- R4: A `coef_ld` sampled while idle opens a write window in the next cycle. For NTAPS consecutive cycles, `coef_in` is captured as tap 0, 1, ... NTAPS-1 in that order.
- R5: `load_done` is high for exactly the one cycle in which the last word is captured. Samples accepted after that cycle use the new bank contents.
- R6: `coef_set_in` is sampled only in the cycle the load request is taken. Later changes during the load have no effect on which bank is written.
- R7: A `coef_ld` that arrives while a load is under way is ignored. The load still ends after NTAPS words, and no second load follows.
- R8: `calc_set` is sampled together with each sample, so results from both banks can be interleaved. A reload into one bank does not change results computed from the other.
- R9: While the bank selected for computing is being reloaded, its previous complete contents stay in use until the load completes.
- R10: A reset after a reload returns both banks to the R1 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for datapath and coefficient loading |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_ld | input | 1 | Request to start a coefficient load |
| coef_set_in | input | 1 | Bank to be written by the load |
| coef_in | input | CW | Serial coefficient word |
| calc_set | input | 1 | Bank used for the sample presented |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_data | output | DW+CW+clog2(NTAPS) | Signed full-precision result |
| load_done | output | 1 | Pulse in the cycle the last coefficient is written |

## Verification
Several checks run on every cycle. The write window must open one cycle after an accepted request and must stay open through the load. The bank being written must hold steady during a load. `load_done` must line up with the NTAPS-th captured word. Both banks may change only at that moment, and each result must come two cycles after its sample. Only the bench scenarios can show that the arithmetic is correct and that words land in arrival order. They also show that the bank switch falls on the exact sample boundary while samples keep streaming, and that reset brings back the default values.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int NSETS = 2;

    // built-in coefficient value for a bank and tap index
    function automatic int dflt_coef(input int set, input int idx);
        return (set == 0) ? idx + 1 : 16 - 4 * idx;
    endfunction
endpackage

// File: rtl/coef_loader.sv
module coef_loader #(
    parameter int NTAPS = 8,
    parameter int CW    = 8,
    localparam int IW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_req,
    input  logic          set_in,
    input  logic [CW-1:0] word_in,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          wr_set,
    output logic [CW-1:0] wr_data,
    output logic          done
);
    localparam logic [IW-1:0] LAST = IW'(NTAPS - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] ptr;
        logic          set;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (ld_req) begin
                st_d.busy = 1'b1;
                st_d.ptr  = '0;
                st_d.set  = set_in;
            end
        end else begin
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ptr == LAST) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.busy;
    assign wr_idx  = st_q.ptr;
    assign wr_set  = st_q.set;
    assign wr_data = word_in;
    assign done    = st_q.busy && (st_q.ptr == LAST);
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
    parameter int NTAPS = 8,
    parameter int CW    = 8,
    localparam int IW   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IW-1:0]                         wr_idx,
    input  logic                                  wr_set,
    input  logic [CW-1:0]                         wr_data,
    input  logic                                  commit,
    output logic [fir_pkg::NSETS-1:0][NTAPS-1:0][CW-1:0] banks
);
    typedef struct packed {
        logic [NTAPS-1:0][CW-1:0]                       stage;
        logic [fir_pkg::NSETS-1:0][NTAPS-1:0][CW-1:0]   bank;
    } st_t;

    function automatic st_t rst_val();
        st_t r;
        r = '0;
        for (int s = 0; s < fir_pkg::NSETS; s++) begin
            for (int i = 0; i < NTAPS; i++) begin
                r.bank[s][i] = CW'(fir_pkg::dflt_coef(s, i));
            end
        end
        return r;
    endfunction

    localparam st_t RST = rst_val();

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.stage[wr_idx] = wr_data;
        end
        // whole set moves into the bank at once, last word included
        if (commit) begin
            st_d.bank[wr_set] = st_d.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign banks = st_q.bank;
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int NTAPS = 8,
    parameter int DW    = 8,
    parameter int CW    = 8,
    localparam int PW   = DW + CW,
    localparam int OW   = DW + CW + $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DW-1:0]            in_data,
    input  logic [NTAPS-1:0][CW-1:0] coefs,
    output logic                     out_valid,
    output logic [OW-1:0]            out_data
);
    typedef logic signed [PW-1:0] prod_t;
    typedef logic signed [OW-1:0] acc_t;

    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0] win;
        logic [NTAPS-1:0][PW-1:0] prod;
        logic                     v1;
        logic [OW-1:0]            sum;
        logic                     v2;
    } st_t;

    st_t st_d, st_q;
    logic [NTAPS-1:0][DW-1:0] nwin;
    acc_t acc;

    always_comb begin
        st_d    = st_q;
        nwin[0] = in_data;
        for (int i = 1; i < NTAPS; i++) begin
            nwin[i] = st_q.win[i-1];
        end
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.win = nwin;
            for (int i = 0; i < NTAPS; i++) begin
                st_d.prod[i] = prod_t'($signed(nwin[i])) * prod_t'($signed(coefs[i]));
            end
        end
        acc = '0;
        for (int i = 0; i < NTAPS; i++) begin
            acc = acc + acc_t'($signed(st_q.prod[i]));
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.sum = acc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.v2;
    assign out_data  = st_q.sum;
endmodule

// File: rtl/fir_reload_top.sv
module fir_reload_top #(
    parameter int NTAPS = 8,
    parameter int DW    = 8,
    parameter int CW    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               coef_ld,
    input  logic                               coef_set_in,
    input  logic [CW-1:0]                      coef_in,
    input  logic                               calc_set,
    input  logic                               in_valid,
    input  logic [DW-1:0]                      in_data,
    output logic                               out_valid,
    output logic [DW+CW+$clog2(NTAPS)-1:0]     out_data,
    output logic                               load_done
);
    localparam int IW = (NTAPS > 1) ? $clog2(NTAPS) : 1;

    logic          ld_we;
    logic [IW-1:0] ld_idx;
    logic          ld_set;
    logic [CW-1:0] ld_word;
    logic [fir_pkg::NSETS-1:0][NTAPS-1:0][CW-1:0] bank_all;
    logic [NTAPS-1:0][CW-1:0] sel_coefs;

    coef_loader #(.NTAPS(NTAPS), .CW(CW)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_req  (coef_ld),
        .set_in  (coef_set_in),
        .word_in (coef_in),
        .wr_en   (ld_we),
        .wr_idx  (ld_idx),
        .wr_set  (ld_set),
        .wr_data (ld_word),
        .done    (load_done)
    );

    coef_bank #(.NTAPS(NTAPS), .CW(CW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_we),
        .wr_idx  (ld_idx),
        .wr_set  (ld_set),
        .wr_data (ld_word),
        .commit  (load_done),
        .banks   (bank_all)
    );

    assign sel_coefs = bank_all[calc_set];

    fir_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .coefs     (sel_coefs),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/fir_reload_chk.sv
module fir_reload_chk #(
    parameter int NTAPS = 8,
    parameter int CW    = 8
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         coef_ld,
    input logic                                         wr_en,
    input logic                                         wr_set,
    input logic                                         load_done,
    input logic                                         in_valid,
    input logic                                         out_valid,
    input logic [fir_pkg::NSETS-1:0][NTAPS-1:0][CW-1:0] banks
);
    localparam int CNW = $clog2(NTAPS) + 1;
    localparam logic [CNW-1:0] LAST = CNW'(NTAPS - 1);

    logic [CNW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         wcnt <= '0;
        else if (load_done) wcnt <= '0;
        else if (wr_en)     wcnt <= wcnt + 1'b1;
    end

    a_r4_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && coef_ld) |=> wr_en);
    a_r4_no_spurious_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !coef_ld) |=> !wr_en);
    a_r5_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (wr_en && wcnt == LAST));
    a_r5_last_flags_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcnt == LAST) |-> load_done);
    a_r6_set_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load_done) |=> $stable(wr_set));
    a_r7_load_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load_done) |=> wr_en);
    a_r9_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |=> $stable(banks));
    a_r3_result_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    a_r3_no_orphan_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
endmodule

bind fir_reload_top fir_reload_chk #(.NTAPS(NTAPS), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .coef_ld   (coef_ld),
    .wr_en     (ld_we),
    .wr_set    (ld_set),
    .load_done (load_done),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .banks     (bank_all)
);

// File: tb/test_fir_reload_top.sv
module test_fir_reload_top;
    localparam int NTAPS = 8;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int OW    = DW + CW + $clog2(NTAPS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_ld = 1'b0;
    logic          coef_set_in = 1'b0;
    logic [CW-1:0] coef_in = '0;
    logic          calc_set = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_data;
    logic          load_done;

    always #4 clk = ~clk;   // 125 MHz

    fir_reload_top #(.NTAPS(NTAPS), .DW(DW), .CW(CW)) i_fir_reload_top (
        .clk(clk), .rst_n(rst_n), .coef_ld(coef_ld), .coef_set_in(coef_set_in),
        .coef_in(coef_in), .calc_set(calc_set), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .load_done(load_done)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 1'b0;
    int    exp_q[$];
    int    cyc_q[$];
    string tag_q[$];
    int mbank[2][NTAPS];
    int mwin[NTAPS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NTAPS; i++) begin
            mbank[0][i] = i + 1;
            mbank[1][i] = 16 - 4 * i;
            mwin[i] = 0;
        end
    endtask

    // driver: present one sample, push its expected result
    task automatic send(input int x, input bit cs, input string req);
        int e;
        @(negedge clk);
        calc_set = cs;
        in_valid = 1'b1;
        in_data  = x[DW-1:0];
        for (int i = NTAPS - 1; i > 0; i--) mwin[i] = mwin[i-1];
        mwin[0] = $signed(x[DW-1:0]);
        e = 0;
        for (int i = 0; i < NTAPS; i++) e += mbank[cs][i] * mwin[i];
        exp_q.push_back(e);
        cyc_q.push_back(cyc);
        tag_q.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic impulse(input bit cs, input string req);
        send(1, cs, req);
        for (int k = 1; k < NTAPS; k++) send(0, cs, req);
        idle(3);
    endtask

    task automatic stream(input int n, input int seed, input bit cs, input string req);
        for (int k = 0; k < n; k++) send(((k * 37 + seed) % 256) - 128, cs, req);
        idle(1);
    endtask

    task automatic load(input bit set, input int w[NTAPS], input bit glitch);
        @(negedge clk);
        coef_ld = 1'b1;
        coef_set_in = set;
        for (int i = 0; i < NTAPS; i++) begin
            @(negedge clk);
            coef_ld = glitch && (i == 3);        // R7: request during a load
            if (glitch && i >= 1) coef_set_in = ~set; // R6: select moves mid-load
            coef_in = w[i][CW-1:0];
            check("R5 load_done on word index", int'(load_done), (i == NTAPS - 1) ? 1 : 0);
        end
        @(posedge clk);
        for (int i = 0; i < NTAPS; i++) mbank[set][i] = w[i];
        @(negedge clk);
        coef_ld = 1'b0;
        coef_set_in = set;
        check("R7 no further load_done", int'(load_done), 0);
        for (int k = 0; k < NTAPS + 2; k++) begin
            @(negedge clk);
            if (load_done) check("R7 second load started", 1, 0);
        end
    endtask

    // monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 result with no sample", 1, 0);
            end else begin
                int e, c;
                string t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check("R3 latency", cyc, c + 2);
                check(t, int'($signed(out_data)), e);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wa[NTAPS];
        int wb[NTAPS];
        int wm[NTAPS];
        for (int i = 0; i < NTAPS; i++) begin
            wa[i] = 3 * i - 11;
            wb[i] = 100 - 29 * i;
            wm[i] = -128;
        end
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 load_done after reset", int'(load_done), 0);

        impulse(1'b0, "R1 bank0 default");
        impulse(1'b1, "R1 bank1 default");
        for (int k = 0; k < 16; k++) send((k * 53) % 256 - 128, k[0], "R8 interleaved banks");
        idle(3);
        stream(12, 7, 1'b0, "R2 mixed pattern");

        fork
            load(1'b1, wa, 1'b1);
            stream(24, 11, 1'b0, "R8 other bank untouched");
        join
        idle(3);
        impulse(1'b1, "R4 arrival order");
        stream(10, 3, 1'b1, "R5 new bank in use");

        fork
            load(1'b1, wb, 1'b0);
            stream(24, 91, 1'b1, "R9 old set until commit");
        join
        idle(3);
        impulse(1'b1, "R9 committed set");

        load(1'b0, wm, 1'b0);
        for (int k = 0; k < 10; k++) send(-128, 1'b0, "R2 full precision");
        idle(4);

        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        check("R10 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        impulse(1'b1, "R10 bank1 restored");
        impulse(1'b0, "R10 bank0 restored");
        idle(4);
        check("R3 all results seen", exp_q.size(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule